// File: doc/BRIEF.md
# Dual-Crossbar Switch Core with Fault Steering

This block is the switching core of a six-port vertical-link router in a clustered 3D mesh network-on-chip. Four planar ports reach the four 2D routers of one cluster. Two vertical ports reach the routers one layer above and one layer below. Every packet is a single flit, and the route for each arriving flit is already computed and comes in with it as a destination port index.

Each input splits into two paths. One path has no storage and feeds a primary crossbar, so a flit that crosses it leaves one cycle after it is accepted. The other path writes the flit into a small per-input FIFO. From there a secondary crossbar drains it, which costs one extra cycle. An arriving flit takes the primary crossbar whenever its output there is free. It falls back to the FIFO only when another arrival holds that output.

Each crossbar has a self-test fault flag as an input. A raised flag removes that crossbar from allocation, so a fault does not take the router out of service. Each output port merges the two crossbars, and the primary side wins that merge. On each crossbar, each output has its own round-robin arbiter.

Top module: `dual_xbar_switch`

## Requirements
- R1: With both fault flags low, a flit that wins the primary crossbar is accepted and appears on its destination output exactly one cycle later, with `out_sec`=0, `out_src` equal to its input index and its data unchanged. It appears there only once. Destination index encoding: 0 east-north, 1 west-north, 2 east-south, 3 west-south, 4 up, 5 down.
- R2: With both flags low, an accepted flit that loses the primary arbitration is stored in its input's FIFO. It appears on its destination two or more cycles after acceptance, with `out_sec`=1.
- R3: When both crossbars have a flit for the same output in the same cycle, the primary flit is delivered first. The buffered flit waits.
- R4: The two crossbars can deliver to different outputs in the same cycle.
- R5: On each crossbar, each output is shared round-robin. After reset the search starts at input 0. After input i is granted an output, the search for that output starts at input i+1, modulo 6.
- R6: With only `pri_fault` high, every accepted flit goes through the FIFO and the secondary crossbar. It leaves two cycles after acceptance if its output is uncontested, with `out_sec`=1.
- R7: With only `sec_fault` high, flits use the primary crossbar only. An input that loses arbitration sees `in_ready`=0, is not accepted, and is delivered once it wins on a later cycle.
- R8: With both flags high, `xbar_err`=1, every `in_ready` is 0 and no output is produced.
- R9: When an input's FIFO is full and that input has not won the primary crossbar, its `in_ready` is 0. Every accepted flit is eventually delivered exactly once.
- R10: After reset with both flags low and no traffic, all `out_valid` are 0, all `in_ready` are 1 and `xbar_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_fault | input | 1 | Primary crossbar fault flag (1 = faulty) |
| sec_fault | input | 1 | Secondary crossbar fault flag (1 = faulty) |
| in_valid | input | 6 | Flit present, one bit per input |
| in_ready | output | 6 | Flit accepted this cycle when valid, one bit per input |
| in_dest | input | 18 | Destination output index, 3 bits per input |
| in_data | input | 48 | Flit payload, 8 bits per input |
| out_valid | output | 6 | Output flit present, one bit per output |
| out_sec | output | 6 | 1 when the output flit came through the secondary crossbar |
| out_src | output | 18 | Input index of the output flit, 3 bits per output |
| out_data | output | 48 | Output flit payload, 8 bits per output |
| xbar_err | output | 1 | Both crossbars flagged faulty |

## Verification
Two states are hard to reach from the ports: a full secondary FIFO, and a primary and a buffered flit contending for one output in the same cycle. The FIFOs normally drain one cycle after they fill. To fill one, the bench holds the primary crossbar faulty while three inputs stream to a single output for many cycles. It then drains the traffic and checks that the accepted and delivered counts and data sums match. To create the same-cycle contention, the bench pushes one flit into a FIFO and, one cycle later, sends a fresh arrival to the same output.

// File: rtl/dual_xbar_switch.sv
module dual_xbar_switch #(
  parameter int NP    = 6,
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int IW   = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_fault,
  input  logic             sec_fault,
  input  logic [NP-1:0]    in_valid,
  output logic [NP-1:0]    in_ready,
  input  logic [NP*IW-1:0] in_dest,
  input  logic [NP*W-1:0]  in_data,
  output logic [NP-1:0]    out_valid,
  output logic [NP-1:0]    out_sec,
  output logic [NP*IW-1:0] out_src,
  output logic [NP*W-1:0]  out_data,
  output logic             xbar_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IW + W;

  function automatic logic [NP-1:0] rr_pick(input logic [NP-1:0] req, input logic [IW-1:0] ptr);
    rr_pick = '0;
    for (int k = NP - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr) + k) % NP;
      if (req[idx]) begin
        rr_pick = '0;
        rr_pick[idx] = 1'b1;
      end
    end
  endfunction

  function automatic logic [IW-1:0] enc(input logic [NP-1:0] oh);
    enc = '0;
    for (int k = 0; k < NP; k++)
      if (oh[k]) enc = IW'(k);
  endfunction

  function automatic logic [IW-1:0] after(input logic [IW-1:0] w);
    after = IW'((int'(w) + 1) % NP);
  endfunction

  logic [NP-1:0] p_req [NP];
  logic [NP-1:0] p_gnt [NP];
  logic [NP-1:0] s_req [NP];
  logic [NP-1:0] s_gnt [NP];
  logic [IW-1:0] p_ptr [NP];
  logic [IW-1:0] s_ptr [NP];
  logic [NP-1:0] p_win, p_busy, pop, push, full;

  logic [EW-1:0] mem [NP][DEPTH];
  logic [AW-1:0] wp  [NP];
  logic [AW-1:0] rp  [NP];
  logic [CW-1:0] cnt [NP];

  always_comb begin
    p_win  = '0;
    p_busy = '0;
    for (int j = 0; j < NP; j++) begin
      for (int i = 0; i < NP; i++)
        p_req[j][i] = !pri_fault && in_valid[i] && (in_dest[i*IW +: IW] == IW'(j));
      p_gnt[j]  = rr_pick(p_req[j], p_ptr[j]);
      p_win     = p_win | p_gnt[j];
      p_busy[j] = |p_gnt[j];
    end
  end

  always_comb begin
    pop = '0;
    for (int j = 0; j < NP; j++) begin
      for (int i = 0; i < NP; i++)
        s_req[j][i] = !sec_fault && (cnt[i] != '0) && !p_busy[j] &&
                      (mem[i][rp[i]][W +: IW] == IW'(j));
      s_gnt[j] = rr_pick(s_req[j], s_ptr[j]);
      pop      = pop | s_gnt[j];
    end
  end

  always_comb
    for (int i = 0; i < NP; i++) full[i] = (cnt[i] == CW'(DEPTH));

  assign push     = in_valid & ~p_win & ~full & {NP{!sec_fault}};
  assign in_ready = p_win | (~full & {NP{!sec_fault}});
  assign xbar_err = pri_fault & sec_fault;

  always_ff @(posedge clk)
    for (int i = 0; i < NP; i++)
      if (push[i]) mem[i][wp[i]] <= {in_dest[i*IW +: IW], in_data[i*W +: W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (push[i]) wp[i] <= (wp[i] == AW'(DEPTH - 1)) ? '0 : wp[i] + 1'b1;
        if (pop[i])  rp[i] <= (rp[i] == AW'(DEPTH - 1)) ? '0 : rp[i] + 1'b1;
        cnt[i] <= cnt[i] + CW'(push[i]) - CW'(pop[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_sec   <= '0;
      out_src   <= '0;
      out_data  <= '0;
      for (int j = 0; j < NP; j++) begin
        p_ptr[j] <= '0;
        s_ptr[j] <= '0;
      end
    end else begin
      for (int j = 0; j < NP; j++) begin
        logic [IW-1:0] pw, sw;
        pw = enc(p_gnt[j]);
        sw = enc(s_gnt[j]);
        if (p_busy[j]) begin
          out_valid[j]           <= 1'b1;
          out_sec[j]             <= 1'b0;
          out_src[j*IW +: IW]    <= pw;
          out_data[j*W +: W]     <= in_data[pw*W +: W];
          p_ptr[j]               <= after(pw);
        end else if (|s_gnt[j]) begin
          out_valid[j]           <= 1'b1;
          out_sec[j]             <= 1'b1;
          out_src[j*IW +: IW]    <= sw;
          out_data[j*W +: W]     <= mem[sw][rp[sw]][W-1:0];
          s_ptr[j]               <= after(sw);
        end else begin
          out_valid[j]           <= 1'b0;
        end
      end
    end
  end

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_fault && sec_fault) |=> (out_valid == '0));

  a_r6_pri_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    pri_fault |=> ((out_valid & ~out_sec) == '0));

  a_r7_sec_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    sec_fault |=> ((out_valid & out_sec) == '0));

  for (genvar g = 0; g < NP; g++) begin : g_chk
    a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(DEPTH));
    a_r9_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == CW'(DEPTH) && !pop[g]) |=> (cnt[g] == CW'(DEPTH)));
  end
endmodule

// File: tb/dual_xbar_switch_tb.sv
module dual_xbar_switch_tb;
  localparam int NP = 6, W = 8, IW = 3;

  logic clk = 0, rst_n = 0, pri_fault = 0, sec_fault = 0;
  logic [NP-1:0] iv = '0;
  logic [NP*IW-1:0] idst = '0;
  logic [NP*W-1:0] idat = '0;
  logic [NP-1:0] in_ready, out_valid, out_sec;
  logic [NP*IW-1:0] out_src;
  logic [NP*W-1:0] out_data;
  logic xbar_err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_xbar_switch u_dut (
    .clk(clk), .rst_n(rst_n), .pri_fault(pri_fault), .sec_fault(sec_fault),
    .in_valid(iv), .in_ready(in_ready), .in_dest(idst), .in_data(idat),
    .out_valid(out_valid), .out_sec(out_sec), .out_src(out_src),
    .out_data(out_data), .xbar_err(xbar_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int i, input int d, input int data);
    iv[i] = 1'b1;
    idst[i*IW +: IW] = IW'(d);
    idat[i*W +: W] = W'(data);
  endtask

  task automatic out_is(input int j, input int src, input int sec, input int data, input string req);
    int act, exp;
    act = (int'(out_valid[j]) << 13) | (int'(out_sec[j]) << 12) |
          (int'(out_src[j*IW +: IW]) << 8) | int'(out_data[j*W +: W]);
    exp = (1 << 13) | (sec << 12) | (src << 8) | data;
    chk(act == exp, req, act, exp);
  endtask

  task automatic only_valid(input logic [NP-1:0] m, input string req);
    chk(out_valid == m, req, int'(out_valid), int'(m));
  endtask

  task automatic do_reset(input logic pf, input logic sf);
    iv = '0;
    pri_fault = pf;
    sec_fault = sf;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(0, 0);
    #1;
    only_valid('0, "R10 out_valid");
    chk(in_ready == '1, "R10 in_ready", int'(in_ready), 63);
    chk(xbar_err == 0, "R10 xbar_err", int'(xbar_err), 0);

    // R1: sweep every input to every output
    for (int i = 0; i < NP; i++)
      for (int d = 0; d < NP; d++) begin
        @(negedge clk);
        iv = '0;
        put(i, d, i * 16 + d);
        @(negedge clk);
        iv = '0;
        out_is(d, i, 0, i * 16 + d, "R1 primary");
        only_valid(NP'(1) << d, "R1 single output");
        @(negedge clk);
        only_valid('0, "R1 no duplicate");
      end

    // R2, R5: two inputs contend for output 0
    do_reset(0, 0);
    put(1, 0, 8'h11); put(3, 0, 8'h33);
    #1 chk(in_ready[3] == 1, "R2 loser accepted", int'(in_ready[3]), 1);
    @(negedge clk); iv = '0;
    out_is(0, 1, 0, 8'h11, "R5 first grant input 0 search");
    @(negedge clk);
    out_is(0, 3, 1, 8'h33, "R2 buffered delivery");
    put(1, 0, 8'h12); put(3, 0, 8'h34);
    @(negedge clk); iv = '0;
    out_is(0, 3, 0, 8'h34, "R5 rotated grant");
    @(negedge clk);
    out_is(0, 1, 1, 8'h12, "R5 rotated loser buffered");
    @(negedge clk);
    only_valid('0, "R2 drained");

    // R3, R4: output priority and simultaneous delivery
    do_reset(0, 0);
    put(0, 2, 8'hA0); put(1, 2, 8'hA1);
    @(negedge clk); iv = '0;
    out_is(2, 0, 0, 8'hA0, "R3 setup");
    put(5, 2, 8'hA5); put(4, 3, 8'hA4);
    @(negedge clk); iv = '0;
    out_is(2, 5, 0, 8'hA5, "R3 primary wins output");
    out_is(3, 4, 0, 8'hA4, "R3 other output");
    put(4, 3, 8'hB4);
    @(negedge clk); iv = '0;
    out_is(2, 1, 1, 8'hA1, "R4 secondary delivers");
    out_is(3, 4, 0, 8'hB4, "R4 primary delivers same cycle");
    only_valid(6'b001100, "R4 outputs");

    // R6: primary faulty
    do_reset(1, 0);
    for (int i = 0; i < NP; i++) begin
      put(i, (i + 1) % NP, 8'hC0 + i);
      #1 chk(in_ready[i] == 1, "R6 accepted", int'(in_ready[i]), 1);
      @(negedge clk); iv = '0;
      only_valid('0, "R6 no primary output");
      @(negedge clk);
      out_is((i + 1) % NP, i, 1, 8'hC0 + i, "R6 secondary path");
    end

    // R7: secondary faulty
    do_reset(0, 1);
    put(0, 1, 8'hD0); put(2, 1, 8'hD2);
    #1 chk(in_ready[0] == 1, "R7 winner ready", int'(in_ready[0]), 1);
    chk(in_ready[2] == 0, "R7 loser held", int'(in_ready[2]), 0);
    @(negedge clk); iv[0] = 0;
    out_is(1, 0, 0, 8'hD0, "R7 winner out");
    #1 chk(in_ready[2] == 1, "R7 held flit ready", int'(in_ready[2]), 1);
    @(negedge clk); iv = '0;
    out_is(1, 2, 0, 8'hD2, "R7 held flit delivered");
    @(negedge clk);
    only_valid('0, "R7 nothing buffered");

    // R8: both faulty
    do_reset(1, 1);
    put(3, 0, 8'hE3); put(5, 4, 8'hE5);
    #1 chk(xbar_err == 1, "R8 error", int'(xbar_err), 1);
    chk(in_ready == '0, "R8 ready", int'(in_ready), 0);
    @(negedge clk);
    only_valid('0, "R8 no output");
    @(negedge clk); iv = '0;
    only_valid('0, "R8 no output later");
    pri_fault = 0; sec_fault = 0;
    #1 chk(xbar_err == 0, "R8 error clears", int'(xbar_err), 0);

    // R9: fill buffers behind one output
    begin
      int acc = 0, dlv = 0, acc_sum = 0, dlv_sum = 0, lows = 0, seq = 0;
      do_reset(1, 0);
      for (int c = 0; c < 60; c++) begin
        if (c > 0) @(negedge clk);
        if (out_valid[5]) begin dlv++; dlv_sum += int'(out_data[5*W +: W]); end
        iv = '0;
        if (c < 30)
          for (int i = 0; i < 3; i++) put(i, 5, (seq + i) % 256);
        #1;
        for (int i = 0; i < 3; i++)
          if (iv[i]) begin
            if (in_ready[i]) begin acc++; acc_sum += int'(idat[i*W +: W]); end
            else lows++;
          end
        if (iv != '0) seq += 3;
      end
      @(negedge clk);
      chk(lows > 0, "R9 backpressure seen", lows, 1);
      chk(acc == dlv, "R9 count conserved", dlv, acc);
      chk(acc_sum == dlv_sum, "R9 data conserved", dlv_sum, acc_sum);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule